// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block compares a real-time clock's current calendar fields with a programmed alarm setting. The fields are second, minute, hour, day of week and date. Each field has its own enable bit. A field that is enabled must equal its alarm value. A field that is disabled is treated as always matching. The alarm condition holds when every enabled field matches in the same cycle and at least one field is enabled.

When the alarm condition rises, the block sets a sticky alarm flag. The flag stays set until software pulses a clear strobe. The interrupt output follows the flag, gated by an interrupt enable.

The counters that keep the time and the register bus that loads the alarm values are outside this block. The time and alarm values arrive on plain input ports.

Top module: `cal_alarm_match`

## Requirements
- R1: Bit `field_en` has one bit per field: bit 0 second, bit 1 minute, bit 2 hour, bit 3 day of week, bit 4 date. A field with its bit set takes part in the comparison.
- R2: A field whose enable bit is clear has no effect on the result, whatever its current and alarm values are.
- R3: The alarm condition is true when all enabled fields equal their alarm values in the same cycle. When it goes from false to true, `alarm_flag` reads 1 after the next rising clock edge.
- R4: Once set, `alarm_flag` stays at 1 while `flag_clr` is low, even after the time moves on. A `flag_clr` pulse with no new rising match clears the flag at the next edge.
- R5: A match that is still present after a clear does not set the flag again. The flag sets again only after the condition has gone false and then become true again.
- R6: When `flag_clr` is high in the same cycle as a new rising match, the flag ends up set.
- R7: With `field_en` equal to 0, the flag never sets, even if every current field equals its alarm value.
- R8: `alarm_irq` is the AND of `alarm_flag` and `irq_en`, with no register between them.
- R9: While `rst_n` is low, and right after it is released, `alarm_flag` and `alarm_irq` read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cur_sec | input | SEC_W | Current second |
| cur_min | input | MIN_W | Current minute |
| cur_hour | input | HOUR_W | Current hour |
| cur_dow | input | DOW_W | Current day of week |
| cur_date | input | DATE_W | Current date |
| alm_sec | input | SEC_W | Alarm second |
| alm_min | input | MIN_W | Alarm minute |
| alm_hour | input | HOUR_W | Alarm hour |
| alm_dow | input | DOW_W | Alarm day of week |
| alm_date | input | DATE_W | Alarm date |
| field_en | input | 5 | Per-field compare enables (R1 order) |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | One-cycle flag clear strobe |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt |

## Verification
The hardest case to reach is a match that persists through a clear. The flag must stay low even though every enabled field still agrees. The bench reaches it by setting the flag, pulsing the clear while the time is held on the alarm value, and stepping several cycles. It then moves the time away for one cycle and back again to show that the flag re-arms. A second hard case is a clear strobe that lands in the same cycle as a fresh match. The bench lines these up by changing the last mismatching field in the same cycle that it raises the strobe.

// File: rtl/cal_alarm_pkg.sv
// Package: shared constants for the calendar alarm comparator.
// Assumes the field order below is also the bit order of the enable vector.
package cal_alarm_pkg;

    localparam int NUM_FIELDS = 5;

    localparam int FLD_SEC  = 0;
    localparam int FLD_MIN  = 1;
    localparam int FLD_HOUR = 2;
    localparam int FLD_DOW  = 3;
    localparam int FLD_DATE = 4;

    // Larger of two widths, used to size the common compare lanes.
    function automatic int wmax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cal_field_cmp.sv
// Module: one compare lane.
// Reports a hit when the lane is disabled, or when the current value equals
// the alarm value. Assumes the inputs are already zero-extended to W bits.
module cal_field_cmp #(
    parameter int W = 6
) (
    input  logic         en,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] alm,
    output logic         hit
);

    // Purpose: a masked lane always agrees; an active lane needs equality.
    always_comb begin
        hit = (!en) || (cur == alm);
    end

endmodule

// File: rtl/cal_match_reduce.sv
// Module: folds the lane results into one alarm condition.
// The condition needs every lane to agree and at least one lane to be enabled,
// so an all-masked setting never fires.
module cal_match_reduce #(
    parameter int N = 5
) (
    input  logic [N-1:0] lane_hit,
    input  logic [N-1:0] lane_en,
    output logic         match
);

    // Purpose: AND of all lane hits, qualified by "any lane enabled".
    always_comb begin
        match = (&lane_hit) && (|lane_en);
    end

endmodule

// File: rtl/cal_flag_ctrl.sv
// Module: edge detector plus sticky flag and interrupt gate.
// Assumes match is a synchronous level. The flag sets on a rising edge of
// match. A clear loses to a simultaneous new edge.
module cal_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic match,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    logic match_q;
    logic rise;
    logic flag_nxt;

    // Purpose: remember last cycle's match level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match;
    end

    // Purpose: next-state of the sticky flag; set has priority over clear.
    always_comb begin
        rise     = match && !match_q;
        flag_nxt = flag;
        if (clr)  flag_nxt = 1'b0;
        if (rise) flag_nxt = 1'b1;
    end

    // Purpose: hold the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= 1'b0;
        else        flag <= flag_nxt;
    end

    // Purpose: interrupt is the flag gated by its enable, no register.
    always_comb begin
        irq = flag && irq_en;
    end

endmodule

// File: rtl/cal_alarm_match.sv
// Module: top of the masked calendar alarm comparator.
// Widens the five fields to a common lane width, compares each lane under its
// enable, reduces the lanes to one condition and drives the sticky flag.
// Assumes all inputs are synchronous to clk.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int SEC_W  = 6,
    parameter int MIN_W  = 6,
    parameter int HOUR_W = 5,
    parameter int DOW_W  = 3,
    parameter int DATE_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEC_W-1:0]      cur_sec,
    input  logic [MIN_W-1:0]      cur_min,
    input  logic [HOUR_W-1:0]     cur_hour,
    input  logic [DOW_W-1:0]      cur_dow,
    input  logic [DATE_W-1:0]     cur_date,
    input  logic [SEC_W-1:0]      alm_sec,
    input  logic [MIN_W-1:0]      alm_min,
    input  logic [HOUR_W-1:0]     alm_hour,
    input  logic [DOW_W-1:0]      alm_dow,
    input  logic [DATE_W-1:0]     alm_date,
    input  logic [NUM_FIELDS-1:0] field_en,
    input  logic                  irq_en,
    input  logic                  flag_clr,
    output logic                  alarm_flag,
    output logic                  alarm_irq
);

    localparam int LANE_W = wmax(wmax(wmax(SEC_W, MIN_W), wmax(HOUR_W, DOW_W)), DATE_W);

    logic [LANE_W-1:0]     cur_lane [NUM_FIELDS];
    logic [LANE_W-1:0]     alm_lane [NUM_FIELDS];
    logic [NUM_FIELDS-1:0] lane_hit;
    logic                  match_all;

    // Purpose: zero-extend each field into its lane slot.
    always_comb begin
        cur_lane[FLD_SEC]  = LANE_W'(cur_sec);
        cur_lane[FLD_MIN]  = LANE_W'(cur_min);
        cur_lane[FLD_HOUR] = LANE_W'(cur_hour);
        cur_lane[FLD_DOW]  = LANE_W'(cur_dow);
        cur_lane[FLD_DATE] = LANE_W'(cur_date);
        alm_lane[FLD_SEC]  = LANE_W'(alm_sec);
        alm_lane[FLD_MIN]  = LANE_W'(alm_min);
        alm_lane[FLD_HOUR] = LANE_W'(alm_hour);
        alm_lane[FLD_DOW]  = LANE_W'(alm_dow);
        alm_lane[FLD_DATE] = LANE_W'(alm_date);
    end

    for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_lane
        cal_field_cmp #(
            .W (LANE_W)
        ) u_cmp (
            .en  (field_en[g]),
            .cur (cur_lane[g]),
            .alm (alm_lane[g]),
            .hit (lane_hit[g])
        );
    end

    cal_match_reduce #(
        .N (NUM_FIELDS)
    ) u_reduce (
        .lane_hit (lane_hit),
        .lane_en  (field_en),
        .match    (match_all)
    );

    cal_flag_ctrl u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .match  (match_all),
        .clr    (flag_clr),
        .irq_en (irq_en),
        .flag   (alarm_flag),
        .irq    (alarm_irq)
    );

endmodule

// File: rtl/cal_alarm_match_chk.sv
// Module: assertion checker for cal_alarm_match, attached by bind below.
// Keeps its own reset-aware copy of the match level so that no property
// looks at values from before reset.
module cal_alarm_match_chk #(
    parameter int NF = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NF-1:0] field_en,
    input logic          irq_en,
    input logic          flag_clr,
    input logic          match_all,
    input logic          alarm_flag,
    input logic          alarm_irq
);

    logic seen_q;

    // Purpose: match level of the previous cycle, forced low in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= match_all;
    end

    // R3: a rising match sets the flag at the next edge
    a_r3_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (match_all && !seen_q) |=> alarm_flag);

    // R4: the flag holds without a clear
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !flag_clr) |=> alarm_flag);

    // R4: a clear with no match empties the flag
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !match_all) |=> !alarm_flag);

    // R5: a persisting match does not set a cleared flag
    a_r5_no_refire: assert property (@(posedge clk) disable iff (!rst_n)
        (match_all && seen_q && !alarm_flag) |=> !alarm_flag);

    // R7: no enabled field keeps a low flag low
    a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
        ((field_en == '0) && !alarm_flag) |=> !alarm_flag);

    // R8: interrupt needs its enable and the flag
    a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (alarm_flag && irq_en));

    // R8: interrupt follows the flag when enabled
    a_r8_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && irq_en) |-> alarm_irq);

endmodule

bind cal_alarm_match cal_alarm_match_chk #(
    .NF (cal_alarm_pkg::NUM_FIELDS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_en   (field_en),
    .irq_en     (irq_en),
    .flag_clr   (flag_clr),
    .match_all  (match_all),
    .alarm_flag (alarm_flag),
    .alarm_irq  (alarm_irq)
);

// File: tb/sim_cal_alarm_match.sv
// Directed bench for cal_alarm_match: one task per scenario.
module sim_cal_alarm_match;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] cur_sec, alm_sec, cur_min, alm_min;
    logic [4:0] cur_hour, alm_hour, cur_date, alm_date;
    logic [2:0] cur_dow, alm_dow;
    logic [4:0] field_en;
    logic       irq_en, flag_clr;
    logic       alarm_flag, alarm_irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cal_alarm_match u0 (
        .clk(clk), .rst_n(rst_n),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
        .cur_dow(cur_dow), .cur_date(cur_date),
        .alm_sec(alm_sec), .alm_min(alm_min), .alm_hour(alm_hour),
        .alm_dow(alm_dow), .alm_date(alm_date),
        .field_en(field_en), .irq_en(irq_en), .flag_clr(flag_clr),
        .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
    );

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic set_time(input int s, input int m, input int h, input int d, input int dt);
        cur_sec = 6'(s); cur_min = 6'(m); cur_hour = 5'(h); cur_dow = 3'(d); cur_date = 5'(dt);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        set_time(0, 0, 0, 0, 0);
        alm_sec = 0; alm_min = 0; alm_hour = 0; alm_dow = 0; alm_date = 0;
        field_en = 5'b11111; irq_en = 1'b1; flag_clr = 1'b0;
        step(3);
        check("R9 flag in reset", alarm_flag, 1'b0);
        check("R9 irq in reset", alarm_irq, 1'b0);
        field_en = 5'b00000;
        rst_n = 1'b1;
        check("R9 flag after release", alarm_flag, 1'b0);
        step();
    endtask

    task automatic t_no_enable();
        field_en = 5'b00000;
        set_time(9, 9, 9, 2, 9);
        alm_sec = 9; alm_min = 9; alm_hour = 9; alm_dow = 2; alm_date = 9;
        step(3);
        check("R7 all masked never fires", alarm_flag, 1'b0);
    endtask

    task automatic t_single_field();
        // R1: bit 0 = second; R2: other fields differ and are masked
        set_time(29, 1, 2, 3, 4);
        alm_sec = 30; alm_min = 50; alm_hour = 20; alm_dow = 6; alm_date = 25;
        field_en = 5'b00001;
        step();
        check("R3 no match yet", alarm_flag, 1'b0);
        cur_sec = 30;
        step();
        check("R2 masked fields ignored, R3 set", alarm_flag, 1'b1);
        clear_flag();
        cur_sec = 0;
        step();
        field_en = 5'b10000; // R1: bit 4 = date only
        cur_date = 25;
        step();
        check("R1 date lane on bit 4", alarm_flag, 1'b1);
        cur_date = 0;
        clear_flag();
    endtask

    task automatic t_all_fields();
        field_en = 5'b11111;
        set_time(30, 50, 20, 6, 24);
        step();
        check("R3 partial match no set", alarm_flag, 1'b0);
        cur_date = 25;
        step();
        check("R3 full match sets", alarm_flag, 1'b1);
    endtask

    task automatic t_sticky_clear();
        cur_min = 51;
        step(3);
        check("R4 sticky after time moves", alarm_flag, 1'b1);
        clear_flag();
        check("R4 clear empties flag", alarm_flag, 1'b0);
    endtask

    task automatic t_no_refire();
        cur_min = 50;
        step();
        check("R5 match sets", alarm_flag, 1'b1);
        clear_flag();
        check("R5 cleared under match", alarm_flag, 1'b0);
        step(3);
        check("R5 persisting match no refire", alarm_flag, 1'b0);
        cur_hour = 21;
        step();
        cur_hour = 20;
        step();
        check("R5 rearmed match sets", alarm_flag, 1'b1);
    endtask

    task automatic t_clr_edge();
        cur_dow = 0;
        step();
        check("R6 precondition flag set", alarm_flag, 1'b1);
        cur_dow = 6;
        flag_clr = 1'b1;
        step();
        flag_clr = 1'b0;
        check("R6 edge beats clear", alarm_flag, 1'b1);
    endtask

    task automatic t_irq();
        irq_en = 1'b0;
        #1;
        check("R8 irq gated off", alarm_irq, 1'b0);
        irq_en = 1'b1;
        #1;
        check("R8 irq follows flag", alarm_irq, 1'b1);
        cur_sec = 0;
        clear_flag();
        check("R8 irq drops with flag", alarm_irq, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_no_enable();
        t_single_field();
        t_all_fields();
        t_sticky_clear();
        t_no_refire();
        t_clr_edge();
        t_irq();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule